// File: doc/BRIEF.md
# Time-Shared Multichannel HDLC Frame Receiver

This block receives HDLC frames from many channels that share one time-division serial highway. Each channel owns one 8-bit timeslot per highway frame. A single receive engine serves all of them. When a channel's timeslot starts, the engine loads that channel's saved context: frame state, ones-run counter, partial octet, buffer position and running CRC-32. It then handles the eight bits of the slot and stores the context again at the end of the slot. Because the partial octet and its bit count are part of the context, an octet can begin in one timeslot and end in a later one, even when zero removal shifts the octet boundaries.

Within a slot the engine hunts for the 0x7E flag. It drops any zero that follows five ones and abandons the frame on seven ones. It assembles octets least significant bit first and writes every octet of the frame, FCS included, into one of two ping-pong buffers per channel. It emits a status word each time a buffer fills and at each closing flag. A status event also sets the channel's pending-interrupt bit, which software clears.

Top module: `hdlcTdmRx`

## Requirements
- R1: A `bitStrobe` together with `fsync` marks bit 0 of channel 0. Each channel then takes 8 consecutive strobes in ascending channel order and wraps after the last channel. Each channel keeps its own context between its slots, so octets continue across slots.
- R2: While `rxEnable` is low, or the channel's bit in `chanEn` is low, that channel writes nothing and reports nothing, and its context returns to idle: flag hunting, buffer 0, index 0.
- R3: Bits before the first 0x7E flag are discarded. After the flag, each group of 8 data bits forms an octet with the first bit received as bit 0. The octet is written with `bufAddr` = {channel, buffer select, index}. The index starts at 0 after a flag.
- R4: A 0 received after exactly five consecutive 1s is removed from the data and from the octet count.
- R5: Seven consecutive 1s inside a frame end it without a status word. The index returns to 0, the buffer select is kept, and the channel hunts for a flag again.
- R6: Writing index BUF_DEPTH-1 produces a status word with bit 0 (full) set and count field = BUF_DEPTH. The buffer select then toggles and the index returns to 0.
- R7: A flag that follows at least one frame octet produces a status word with bit 1 (EOF) set and count field = octets in the current buffer (0 if the last octet filled the previous one). The buffer select then toggles.
- R8: At EOF, bit 2 (CRC error) is set unless the CRC-32 register ends at 0xDEBB20E3. The register is preset to all ones at the flag, runs reflected, and is updated over every frame octet including the FCS.
- R9: At EOF, with frame length counted in octets including the FCS, bit 3 is set when the length is above MAX_LEN and bit 4 when it is below MIN_LEN. Bit 5 (OK) is set only when bits 2 to 4 are all clear.
- R10: Every status word sets `irqPend` for its channel. A high `irqClr` bit clears that channel's bit, but a set in the same cycle wins. `irq` is the OR of all `irqPend` bits.
- R11: After reset, `bufWe`, `statWe`, `irqPend` and `irq` are all 0.

The status word holds its flags in bits 5:0 and the count field in bits above them. Buffer writes and status words appear as one-cycle pulses in the clock cycle after the strobe that caused them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitIn | input | 1 | Received highway bit |
| bitStrobe | input | 1 | One-cycle strobe: `bitIn` is valid |
| fsync | input | 1 | With `bitStrobe`, marks bit 0 of channel 0 |
| rxEnable | input | 1 | Global receive enable |
| chanEn | input | NUM_CH | Per-channel receive enable |
| irqClr | input | NUM_CH | Per-channel interrupt clear |
| bufWe | output | 1 | Buffer octet write strobe |
| bufAddr | output | CH_W+1+IDX_W | {channel, buffer select, index} |
| bufData | output | 8 | Octet written |
| statWe | output | 1 | Status word strobe |
| statCh | output | CH_W | Channel of the status word |
| statBuf | output | 1 | Buffer the status word describes |
| statWord | output | 6+IDX_W+1 | {count, OK, short, long, CRC error, EOF, full} |
| irqPend | output | NUM_CH | Pending interrupt per channel |
| irq | output | 1 | OR of `irqPend` |

## Verification
Several channels carry traffic at once, so a context mix-up between timeslots shows up as a wrong channel or a wrong index. One frame contains 0xFF, 0x7E and 0xFC octets; these force zero insertion and push octets across slot boundaries. Other frames separate the status outcomes: a clean frame that spills across both buffers, a corrupted FCS, a frame that is too short, a frame that is too long, and a frame that ends exactly on a buffer boundary. Further cases send an aborted frame followed by a good one, traffic on a disabled channel, and traffic while global receive is off. Together these expose a lost reset of the buffer select or index, a lost abort, and a gate that leaks.

// File: rtl/hdlcRxPkg.sv
package hdlcRxPkg;
  localparam logic [7:0]  FLAG_PATTERN = 8'h7E;
  localparam logic [31:0] CRC_POLY     = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE  = 32'hDEBB20E3;

  localparam int ST_FULL  = 0;
  localparam int ST_EOF   = 1;
  localparam int ST_CRC   = 2;
  localparam int ST_LONG  = 3;
  localparam int ST_SHORT = 4;
  localparam int ST_OK    = 5;
  localparam int ST_FLAGS = 6;

  typedef struct packed {
    logic tick;  // a bit is being processed this cycle
    logic load;  // take context from the store
    logic save;  // write context back to the store
    logic live;  // channel enabled for reception
  } rxStrobe_t;

  function automatic logic [31:0] crcOctet(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/hdlcRxSlotCtl.sv
module hdlcRxSlotCtl
  import hdlcRxPkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int CH_W = $clog2(NUM_CH)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitStrobe,
  input  logic              fsync,
  input  logic              rxEnable,
  input  logic [NUM_CH-1:0] chanEn,
  output rxStrobe_t         strb,
  output logic [CH_W-1:0]   curCh
);
  logic            synced;
  logic [CH_W-1:0] nextCh;
  logic [2:0]      nextBit;
  logic [2:0]      curBit;
  logic            valid;

  always_comb begin
    curCh     = fsync ? '0 : nextCh;
    curBit    = fsync ? 3'd0 : nextBit;
    valid     = bitStrobe && (fsync || synced);
    strb.tick = valid;
    strb.load = valid && (curBit == 3'd0);
    strb.save = valid && (curBit == 3'd7);
    strb.live = rxEnable && chanEn[curCh];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      synced  <= 1'b0;
      nextCh  <= '0;
      nextBit <= '0;
    end else if (valid) begin
      synced  <= 1'b1;
      nextBit <= curBit + 3'd1;
      if (curBit == 3'd7)
        nextCh <= (curCh == CH_W'(NUM_CH - 1)) ? '0 : curCh + CH_W'(1);
    end
  end
endmodule

// File: rtl/hdlcRxCtxStore.sv
module hdlcRxCtxStore #(
  parameter int NUM_CH = 32,
  parameter int CTX_W  = 64,
  localparam int CH_W = $clog2(NUM_CH)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CH_W-1:0]  ch,
  input  logic             wrEn,
  input  logic [CTX_W-1:0] wrData,
  output logic [CTX_W-1:0] rdData
);
  logic [CTX_W-1:0] mem [NUM_CH];

  assign rdData = mem[ch];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) mem[i] <= '0;
    end else if (wrEn) begin
      mem[ch] <= wrData;
    end
  end
endmodule

// File: rtl/hdlcRxBitPath.sv
module hdlcRxBitPath
  import hdlcRxPkg::*;
#(
  parameter int NUM_CH    = 32,
  parameter int BUF_DEPTH = 8,
  parameter int MIN_LEN   = 6,
  parameter int MAX_LEN   = 32,
  parameter int CTX_W     = 64,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int IDX_W  = $clog2(BUF_DEPTH),
  localparam int CNT_W  = IDX_W + 1,
  localparam int LEN_W  = $clog2(MAX_LEN + 2),
  localparam int ADDR_W = CH_W + 1 + IDX_W,
  localparam int STAT_W = ST_FLAGS + CNT_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic [CH_W-1:0]   curCh,
  input  logic              bitIn,
  input  logic [CTX_W-1:0]  ctxRd,
  output logic [CTX_W-1:0]  ctxWr,
  input  logic [NUM_CH-1:0] irqClr,
  output logic              bufWe,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [7:0]        bufData,
  output logic              statWe,
  output logic [CH_W-1:0]   statCh,
  output logic              statBuf,
  output logic [STAT_W-1:0] statWord,
  output logic [NUM_CH-1:0] irqPend
);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN + 1);

  typedef struct packed {
    logic             inFrame;
    logic [2:0]       onesRun;
    logic [7:0]       rawHist;
    logic [7:0]       octet;
    logic [2:0]       bitCnt;
    logic [LEN_W-1:0] byteCnt;
    logic [IDX_W-1:0] bufIdx;
    logic             pingPong;
    logic [31:0]      crc;
  } ctx_t;

  ctx_t work, cur, nxt;
  logic wrEv, stEv;
  logic [ST_FLAGS-1:0] stFlags;
  logic [CNT_W-1:0]    stCnt;
  logic [7:0] octNew, hist;
  logic [2:0] ones;

  always_comb begin
    cur     = strb.load ? ctx_t'(ctxRd) : work;
    nxt     = cur;
    wrEv    = 1'b0;
    stEv    = 1'b0;
    stFlags = '0;
    stCnt   = '0;
    octNew  = {bitIn, cur.octet[7:1]};
    hist    = {bitIn, cur.rawHist[7:1]};
    ones    = !bitIn ? 3'd0 : ((cur.onesRun == 3'd7) ? 3'd7 : cur.onesRun + 3'd1);
    if (!strb.live) begin
      nxt = '0;
    end else begin
      nxt.rawHist = hist;
      nxt.onesRun = ones;
      if (hist == FLAG_PATTERN) begin
        if (cur.inFrame && (cur.byteCnt != '0)) begin
          stEv              = 1'b1;
          stFlags[ST_EOF]   = 1'b1;
          stFlags[ST_CRC]   = (cur.crc != CRC_RESIDUE);
          stFlags[ST_LONG]  = (cur.byteCnt > LEN_W'(MAX_LEN));
          stFlags[ST_SHORT] = (cur.byteCnt < LEN_W'(MIN_LEN));
          stFlags[ST_OK]    = !(stFlags[ST_CRC] || stFlags[ST_LONG] || stFlags[ST_SHORT]);
          stCnt             = CNT_W'(cur.bufIdx);
          nxt.pingPong      = ~cur.pingPong;
          nxt.bufIdx        = '0;
        end
        nxt.inFrame = 1'b1;
        nxt.byteCnt = '0;
        nxt.bitCnt  = '0;
        nxt.octet   = '0;
        nxt.crc     = '1;
      end else if (!cur.inFrame) begin
        nxt.bitCnt = '0;
      end else if (ones == 3'd7) begin
        nxt.inFrame = 1'b0;
        nxt.bufIdx  = '0;
        nxt.bitCnt  = '0;
        nxt.byteCnt = '0;
      end else if (!bitIn && (cur.onesRun == 3'd5)) begin
        nxt.bitCnt = cur.bitCnt;  // inserted zero: not data
      end else begin
        nxt.octet  = octNew;
        nxt.bitCnt = cur.bitCnt + 3'd1;
        if (cur.bitCnt == 3'd7) begin
          wrEv    = 1'b1;
          nxt.crc = crcOctet(cur.crc, octNew);
          if (cur.byteCnt != LEN_CAP) nxt.byteCnt = cur.byteCnt + LEN_W'(1);
          if (cur.bufIdx == IDX_W'(BUF_DEPTH - 1)) begin
            stEv             = 1'b1;
            stFlags[ST_FULL] = 1'b1;
            stCnt            = CNT_W'(BUF_DEPTH);
            nxt.pingPong     = ~cur.pingPong;
            nxt.bufIdx       = '0;
          end else begin
            nxt.bufIdx = cur.bufIdx + IDX_W'(1);
          end
        end
      end
    end
  end

  assign ctxWr = nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      work     <= '0;
      bufWe    <= 1'b0;
      bufAddr  <= '0;
      bufData  <= '0;
      statWe   <= 1'b0;
      statCh   <= '0;
      statBuf  <= 1'b0;
      statWord <= '0;
      irqPend  <= '0;
    end else begin
      bufWe  <= strb.tick && wrEv;
      statWe <= strb.tick && stEv;
      if (strb.tick) begin
        work <= nxt;
        if (wrEv) begin
          bufAddr <= {curCh, cur.pingPong, cur.bufIdx};
          bufData <= octNew;
        end
        if (stEv) begin
          statCh   <= curCh;
          statBuf  <= cur.pingPong;
          statWord <= {stCnt, stFlags};
        end
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (strb.tick && stEv && (curCh == CH_W'(c))) irqPend[c] <= 1'b1;
        else if (irqClr[c])                           irqPend[c] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hdlcTdmRx.sv
module hdlcTdmRx
  import hdlcRxPkg::*;
#(
  parameter int NUM_CH    = 32,
  parameter int BUF_DEPTH = 8,
  parameter int MIN_LEN   = 6,
  parameter int MAX_LEN   = 32,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int IDX_W  = $clog2(BUF_DEPTH),
  localparam int CNT_W  = IDX_W + 1,
  localparam int LEN_W  = $clog2(MAX_LEN + 2),
  localparam int ADDR_W = CH_W + 1 + IDX_W,
  localparam int STAT_W = ST_FLAGS + CNT_W,
  localparam int CTX_W  = 56 + LEN_W + IDX_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  logic              bitStrobe,
  input  logic              fsync,
  input  logic              rxEnable,
  input  logic [NUM_CH-1:0] chanEn,
  input  logic [NUM_CH-1:0] irqClr,
  output logic              bufWe,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [7:0]        bufData,
  output logic              statWe,
  output logic [CH_W-1:0]   statCh,
  output logic              statBuf,
  output logic [STAT_W-1:0] statWord,
  output logic [NUM_CH-1:0] irqPend,
  output logic              irq
);
  rxStrobe_t        strb;
  logic [CH_W-1:0]  curCh;
  logic [CTX_W-1:0] ctxRd, ctxWr;

  hdlcRxSlotCtl #(.NUM_CH(NUM_CH)) u_ctl (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .fsync(fsync),
    .rxEnable(rxEnable), .chanEn(chanEn), .strb(strb), .curCh(curCh)
  );

  hdlcRxCtxStore #(.NUM_CH(NUM_CH), .CTX_W(CTX_W)) u_store (
    .clk(clk), .rstN(rstN), .ch(curCh), .wrEn(strb.save),
    .wrData(ctxWr), .rdData(ctxRd)
  );

  hdlcRxBitPath #(
    .NUM_CH(NUM_CH), .BUF_DEPTH(BUF_DEPTH), .MIN_LEN(MIN_LEN),
    .MAX_LEN(MAX_LEN), .CTX_W(CTX_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .curCh(curCh), .bitIn(bitIn),
    .ctxRd(ctxRd), .ctxWr(ctxWr), .irqClr(irqClr),
    .bufWe(bufWe), .bufAddr(bufAddr), .bufData(bufData),
    .statWe(statWe), .statCh(statCh), .statBuf(statBuf),
    .statWord(statWord), .irqPend(irqPend)
  );

  assign irq = |irqPend;
endmodule

// File: rtl/hdlcTdmRxChk.sv
module hdlcTdmRxChk #(
  parameter int NUM_CH    = 32,
  parameter int BUF_DEPTH = 8,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int IDX_W  = $clog2(BUF_DEPTH),
  localparam int CNT_W  = IDX_W + 1,
  localparam int STAT_W = 6 + CNT_W
)(
  input logic              clk,
  input logic              rstN,
  input logic              bitStrobe,
  input logic              rxEnable,
  input logic              bufWe,
  input logic              statWe,
  input logic [CH_W-1:0]   statCh,
  input logic [STAT_W-1:0] statWord,
  input logic [NUM_CH-1:0] irqPend
);
  a_r1_write_follows_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (bufWe || statWe) |-> $past(bitStrobe));

  a_r2_gated_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (bitStrobe && !rxEnable) |=> (!bufWe && !statWe));

  a_r6_full_count: assert property (@(posedge clk) disable iff (!rstN)
    (statWe && statWord[0]) |-> (statWord[STAT_W-1:6] == CNT_W'(BUF_DEPTH)));

  a_r7_eof_not_full: assert property (@(posedge clk) disable iff (!rstN)
    (statWe && statWord[1]) |-> !statWord[0]);

  a_r9_ok_clean: assert property (@(posedge clk) disable iff (!rstN)
    (statWe && statWord[5]) |-> (statWord[1] && (statWord[4:2] == 3'b000)));

  a_r10_irq_raised: assert property (@(posedge clk) disable iff (!rstN)
    statWe |-> irqPend[statCh]);
endmodule

bind hdlcTdmRx hdlcTdmRxChk #(.NUM_CH(NUM_CH), .BUF_DEPTH(BUF_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .rxEnable(rxEnable),
  .bufWe(bufWe), .statWe(statWe), .statCh(statCh), .statWord(statWord),
  .irqPend(irqPend)
);

// File: tb/hdlcTdmRx_tb.sv
module hdlcTdmRx_tb;
  localparam int NUM_CH    = 32;
  localparam int BUF_DEPTH = 8;
  localparam int MIN_LEN   = 6;
  localparam int MAX_LEN   = 32;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int IDX_W  = $clog2(BUF_DEPTH);
  localparam int CNT_W  = IDX_W + 1;
  localparam int ADDR_W = CH_W + 1 + IDX_W;
  localparam int STAT_W = 6 + CNT_W;

  typedef struct packed {
    logic              isStat;
    logic              bsel;
    logic [IDX_W-1:0]  idx;
    logic [7:0]        data;
    logic [STAT_W-1:0] word;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitIn = 1'b1, bitStrobe = 1'b0, fsync = 1'b0, rxEnable = 1'b0;
  logic [NUM_CH-1:0] chanEn = '0, irqClr = '0;
  logic bufWe, statWe, statBuf, irq;
  logic [ADDR_W-1:0] bufAddr;
  logic [7:0] bufData;
  logic [CH_W-1:0] statCh;
  logic [STAT_W-1:0] statWord;
  logic [NUM_CH-1:0] irqPend;

  int total = 0, bad = 0;
  bit done = 0;
  bit txQ [NUM_CH][$];
  expItem_t expQ [NUM_CH][$];
  logic mPp [NUM_CH];
  int   mIdx [NUM_CH];
  string chTag [NUM_CH];
  logic [NUM_CH-1:0] expIrq = '0;

  always #10 clk = ~clk;  // 50 MHz

  hdlcTdmRx #(.NUM_CH(NUM_CH), .BUF_DEPTH(BUF_DEPTH), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_dut (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitStrobe(bitStrobe), .fsync(fsync),
    .rxEnable(rxEnable), .chanEn(chanEn), .irqClr(irqClr), .bufWe(bufWe),
    .bufAddr(bufAddr), .bufData(bufData), .statWe(statWe), .statCh(statCh),
    .statBuf(statBuf), .statWord(statWord), .irqPend(irqPend), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] benchCrc(input logic [7:0] bytesIn[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (bytesIn[k])
      for (int i = 0; i < 8; i++)
        c = (c[0] ^ bytesIn[k][i]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return c;
  endfunction

  task automatic pushRaw(input int ch, input logic [7:0] b);
    for (int i = 0; i < 8; i++) txQ[ch].push_back(b[i]);
  endtask

  task automatic pushStat(input int ch, input logic [5:0] flags, input int cnt);
    expItem_t it;
    it = '0;
    it.isStat = 1'b1;
    it.bsel = mPp[ch];
    it.word = {CNT_W'(cnt), flags};
    expQ[ch].push_back(it);
    expIrq[ch] = 1'b1;
    mPp[ch] = ~mPp[ch];
    mIdx[ch] = 0;
  endtask

  task automatic pushData(input int ch, input logic [7:0] b);
    expItem_t it;
    it = '0;
    it.bsel = mPp[ch];
    it.idx = IDX_W'(mIdx[ch]);
    it.data = b;
    expQ[ch].push_back(it);
    mIdx[ch]++;
    if (mIdx[ch] == BUF_DEPTH) pushStat(ch, 6'b000001, BUF_DEPTH);
  endtask

  // flag, stuffed octets, then closing flag or seven-plus ones
  task automatic sendFrame(input int ch, input logic [7:0] pl[$], input bit badFcs,
                           input bit abortIt, input bit expectOn);
    logic [7:0] fr[$];
    logic [31:0] fcs;
    int run = 0;
    fr = pl;
    if (!abortIt) begin
      fcs = ~benchCrc(pl);
      if (badFcs) fcs = fcs ^ 32'h1;
      for (int k = 0; k < 4; k++) fr.push_back(fcs[8*k +: 8]);
    end
    pushRaw(ch, 8'h7E);
    foreach (fr[k]) begin
      for (int i = 0; i < 8; i++) begin
        txQ[ch].push_back(fr[k][i]);
        if (fr[k][i]) run++; else run = 0;
        if (run == 5) begin txQ[ch].push_back(1'b0); run = 0; end
      end
      if (expectOn) pushData(ch, fr[k]);
    end
    if (abortIt) begin
      pushRaw(ch, 8'hFF);
      if (expectOn) mIdx[ch] = 0;
    end else begin
      pushRaw(ch, 8'h7E);
      if (expectOn) begin
        logic [5:0] fl;
        fl = '0;
        fl[1] = 1'b1;
        fl[2] = badFcs;
        fl[3] = (fr.size() > MAX_LEN);
        fl[4] = (fr.size() < MIN_LEN);
        fl[5] = !(fl[2] || fl[3] || fl[4]);
        pushStat(ch, fl, mIdx[ch]);
      end
    end
  endtask

  task automatic drain();
    int pend;
    do begin
      @(negedge clk);
      pend = 0;
      for (int c = 0; c < NUM_CH; c++) pend += txQ[c].size();
    end while (pend != 0);
    repeat (1100) @(negedge clk);
    for (int c = 0; c < NUM_CH; c++)
      check(expQ[c].size() == 0, chTag[c], $sformatf("items still expected ch%0d", c), 0, expQ[c].size());
  endtask

  // highway driver: 8 bits per channel, idle ones when a channel has no traffic
  initial begin
    wait (rstN);
    forever begin
      for (int c = 0; c < NUM_CH; c++) begin
        for (int b = 0; b < 8; b++) begin
          @(negedge clk);
          bitIn = (txQ[c].size() != 0) ? txQ[c].pop_front() : 1'b1;
          bitStrobe = 1'b1;
          fsync = (c == 0) && (b == 0);
          @(negedge clk);
          bitStrobe = 1'b0;
          fsync = 1'b0;
        end
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (bufWe) begin
        int c;
        c = int'(bufAddr[ADDR_W-1 -: CH_W]);
        if (expQ[c].size() == 0) check(0, chTag[c], $sformatf("unexpected octet ch%0d", c), bufData, 0);
        else begin
          expItem_t e;
          e = expQ[c].pop_front();
          check(!e.isStat && (bufAddr[IDX_W:0] == {e.bsel, e.idx}) && (bufData == e.data), chTag[c],
                $sformatf("octet ch%0d {sel,idx,data}", c),
                {bufAddr[IDX_W:0], bufData}, {e.isStat, e.bsel, e.idx, e.data});
        end
      end
      if (statWe) begin
        int c;
        c = int'(statCh);
        if (expQ[c].size() == 0) check(0, chTag[c], $sformatf("unexpected status ch%0d", c), statWord, 0);
        else begin
          expItem_t e;
          e = expQ[c].pop_front();
          check(e.isStat && (statBuf == e.bsel) && (statWord == e.word), chTag[c],
                $sformatf("status ch%0d {buf,word}", c), {statBuf, statWord}, {e.bsel, e.word});
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      check(0, "R1", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pl[$];
    for (int c = 0; c < NUM_CH; c++) begin mPp[c] = 0; mIdx[c] = 0; chTag[c] = "R3"; end
    repeat (3) @(negedge clk);
    // R11: reset state
    check(bufWe == 0, "R11", "bufWe", bufWe, 0);
    check(statWe == 0, "R11", "statWe", statWe, 0);
    check(irqPend == 0, "R11", "irqPend", irqPend, 0);
    check(irq == 0, "R11", "irq", irq, 0);
    rstN = 1'b1;
    rxEnable = 1'b1;
    chanEn = '1;
    chanEn[2] = 1'b0;

    // R1 R3 R4: leading junk, stuffing-heavy octets, spill over a buffer
    chTag[0] = "R1 R3 R4 R6";
    pushRaw(0, 8'h00); pushRaw(0, 8'h00);
    pl = '{8'hFF, 8'h7E, 8'h3E, 8'h00, 8'h81, 8'hFC};
    sendFrame(0, pl, 0, 0, 1);
    chTag[5] = "R8";
    pl = '{8'h10, 8'h20, 8'h30};
    sendFrame(5, pl, 1, 0, 1);
    chTag[7] = "R9";
    pl = '{8'h5A};
    sendFrame(7, pl, 0, 0, 1);
    chTag[9] = "R6 R9";
    pl = {};
    for (int k = 0; k < 30; k++) pl.push_back(8'(k * 7 + 3));
    sendFrame(9, pl, 0, 0, 1);
    chTag[2] = "R2";
    pl = '{8'h11, 8'h22, 8'h33};
    sendFrame(2, pl, 0, 0, 0);
    chTag[3] = "R5";
    pl = '{8'h11, 8'h22, 8'h33};
    sendFrame(3, pl, 0, 1, 1);
    pl = '{8'hA5, 8'hC3};
    sendFrame(3, pl, 0, 0, 1);
    chTag[13] = "R7";
    pl = '{8'h01, 8'h02, 8'h03, 8'h04};
    sendFrame(13, pl, 0, 0, 1);
    drain();

    // R10: pending bits and their clearing
    check(irqPend == expIrq, "R10", "irqPend after traffic", irqPend, expIrq);
    check(irq == 1'b1, "R10", "irq after traffic", irq, 1);
    irqClr = '1;
    @(negedge clk);
    irqClr = '0;
    check(irqPend == 0, "R10", "irqPend after clear", irqPend, 0);
    check(irq == 1'b0, "R10", "irq after clear", irq, 0);

    // R2: global enable off, then back on with contexts back at buffer 0
    rxEnable = 1'b0;
    chTag[11] = "R2";
    pl = '{8'h44, 8'h55, 8'h66};
    sendFrame(11, pl, 0, 0, 0);
    drain();
    check(irqPend == 0, "R2", "irqPend while disabled", irqPend, 0);
    for (int c = 0; c < NUM_CH; c++) begin mPp[c] = 0; mIdx[c] = 0; end
    rxEnable = 1'b1;
    chTag[0] = "R2 R3";
    chTag[11] = "R2 R3";
    pl = '{8'h44, 8'h55, 8'h66};
    sendFrame(11, pl, 0, 0, 1);
    pl = '{8'h99, 8'h88};
    sendFrame(0, pl, 0, 0, 1);
    drain();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule